// File: doc/BRIEF.md
# Vectored 64-Source Interrupt Controller

This block gathers 64 level-sensitive interrupt lines and steers each one to one of two request outputs. The normal request goes out on `norm_req` and the fast request on `fast_req`. Every source has its own enable bit, its own routing (type) bit, a software force bit and a 4-bit priority. A priority-level threshold can hold back low-priority normal sources. Two status words name the winning source. For the normal path the winner is the highest priority, with ties going to the higher source number. For the fast path the winner is the highest-numbered pending source.

Software reaches the controller through a simple single-cycle register port. A write is taken on the rising edge where `bus_wr` is high. Read data is combinational from `bus_addr`. Addresses are word indices: byte offset divided by four. The source inputs are assumed to be synchronous to `clk` already. Written state takes effect on the clock edge that captures the write. The request outputs and status words follow state and inputs with no further register.

Word map, by word address: 0 control (plain storage), 1 level threshold, 2 set-enable-by-number, 3 clear-enable-by-number, 4/5 enable high/low, 6/7 type high/low, 8..15 priority words, 16 normal status, 17 fast status, 18/19 raw line state high/low, 20/21 force high/low, 22/23 normal pending high/low, 24/25 fast pending high/low. Unmapped words and the two by-number words read 0.

Top module: `vic_ctrl`

## Requirements
- R1: After reset the control, enable, type, force and priority state all read 0, the level threshold reads 0x1F, both status words read 0xFFFF0000, and both request outputs are low.
- R2: Control, enable, type and force words read back the value last written to them. In every high/low pair, bit k of the low word belongs to source k and bit k of the high word belongs to source 32+k.
- R3: Writing a value n below 64 to word 2 sets the enable bit of source n, and writing it to word 3 clears that bit. All other enable bits keep their values. A value of 64 or more written to either word changes nothing.
- R4: A source is asserted when its input line or its force bit is 1. Words 18/19 show the input lines alone.
- R5: A normal pending bit is 1 exactly when its source is asserted, enabled, has type 0 and passes the level threshold. A disabled source is never pending.
- R6: A fast pending bit is 1 exactly when its source is asserted, enabled and has type 1, whatever its priority and the level threshold.
- R7: The normal status word carries, in bits 31:16, the pending normal source with the highest priority, ties going to the higher source number. It reads 0xFFFF there when none is pending. Bits 15:0 read 0.
- R8: Threshold bit 4 set means no source is held back. Otherwise a normal source passes only if its priority is strictly greater than threshold bits 3:0.
- R9: Priority word x (x = 0..7) is at word address 15 − x. It holds sources 8x..8x+7, and source 8x+k sits in bits 4k+3:4k.
- R10: The fast status word carries, in bits 31:16, the highest-numbered fast pending source, or 0xFFFF when none is pending. Bits 15:0 read 0.
- R11: `norm_req` is high exactly when some normal pending bit is set, and `fast_req` is high exactly when some fast pending bit is set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| bus_wr | input | 1 | Write strobe, taken on the rising edge |
| bus_addr | input | 5 | Word address of the register |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Combinational read data for `bus_addr` |
| src_in | input | 64 | Interrupt input lines, level sensitive |
| norm_req | output | 1 | Normal interrupt request, active high |
| fast_req | output | 1 | Fast interrupt request, active high |

## Verification
A corrupted enable, type, force or priority bit is visible in the cycle right after the write that set it. It shows up on the pending words and on the request outputs, and when the bit touches the arbitration it also shows in a status word. A bad tie-break or a bad threshold compare only shows when two sources with chosen priorities compete. The stimulus therefore builds equal and unequal priority pairs and sets threshold values on both sides of them. Every status read is compared against a winner computed from the requirements. The checker also ties each status word to a pending bit that is set, in every cycle.

// File: rtl/vic_pkg.sv
// Package: shared sizes and the word map of the interrupt controller.
// Assumes 64 sources split across 32-bit high/low register pairs.
package vic_pkg;
    localparam int NUM_SRC = 64;
    localparam int PRIO_W  = 4;
    localparam int DATA_W  = 32;
    localparam int ADDR_W  = 5;

    // Word addresses (byte offset / 4).
    typedef enum logic [ADDR_W-1:0] {
        W_CTL   = 5'd0,  W_LVL   = 5'd1,  W_ENSET = 5'd2,  W_ENCLR = 5'd3,
        W_ENH   = 5'd4,  W_ENL   = 5'd5,  W_TYH   = 5'd6,  W_TYL   = 5'd7,
        W_NVEC  = 5'd16, W_FVEC  = 5'd17, W_RAWH  = 5'd18, W_RAWL  = 5'd19,
        W_FRCH  = 5'd20, W_FRCL  = 5'd21, W_NPH   = 5'd22, W_NPL   = 5'd23,
        W_FPH   = 5'd24, W_FPL   = 5'd25
    } vic_word_e;

    // Priority words occupy 8..15; word index x lives at 15 - x.
    localparam logic [ADDR_W-1:0] W_PRIO_BASE = 5'd8;
    localparam logic [15:0]       VEC_NONE    = 16'hFFFF;
endpackage

// File: rtl/vic_regs.sv
// Module: register file and read multiplexer of the interrupt controller.
// Holds control, threshold, enable, type, force and priority state; applies
// by-number enable updates. Assumes one access per cycle, reads combinational.
module vic_regs
    import vic_pkg::*;
#(
    parameter int N  = NUM_SRC,
    parameter int PW = PRIO_W,
    parameter int DW = DATA_W,
    parameter int AW = ADDR_W
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            bus_wr,
    input  logic [AW-1:0]   bus_addr,
    input  logic [DW-1:0]   bus_wdata,
    output logic [DW-1:0]   bus_rdata,
    input  logic [N-1:0]    src_in,
    input  logic [N-1:0]    npend,
    input  logic [N-1:0]    fpend,
    input  logic [DW-1:0]   nvec_word,
    input  logic [DW-1:0]   fvec_word,
    output logic [N-1:0]    en_q,
    output logic [N-1:0]    typ_q,
    output logic [N-1:0]    frc_q,
    output logic [N*PW-1:0] prio_q,
    output logic [4:0]      lvl_q
);
    localparam int IW   = $clog2(N);
    localparam int HALF = N / 2;
    localparam int NPW  = (N * PW) / DW;   // number of priority words

    logic [DW-1:0]          ctl_q;
    logic                   num_ok;
    logic                   is_prio;
    logic [$clog2(NPW)-1:0] pw_idx;

    // By-number writes only act on a valid source number.
    assign num_ok  = (bus_wdata < DW'(N));
    // Priority words sit in the upper half of the first sixteen words.
    assign is_prio = (bus_addr >= W_PRIO_BASE) && (bus_addr < W_PRIO_BASE + AW'(NPW));
    // Index x is stored at base + NPW - 1 - x.
    assign pw_idx  = $clog2(NPW)'(AW'(NPW - 1) - (bus_addr - W_PRIO_BASE));

    // Register writes with synchronous active-low reset.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ctl_q  <= '0;
            lvl_q  <= 5'h1F;
            en_q   <= '0;
            typ_q  <= '0;
            frc_q  <= '0;
            prio_q <= '0;
        end else if (bus_wr) begin
            if (is_prio) begin
                prio_q[pw_idx*DW +: DW] <= bus_wdata;
            end
            case (bus_addr)
                W_CTL:   ctl_q             <= bus_wdata;
                W_LVL:   lvl_q             <= bus_wdata[4:0];
                W_ENSET: if (num_ok) en_q[bus_wdata[IW-1:0]] <= 1'b1;
                W_ENCLR: if (num_ok) en_q[bus_wdata[IW-1:0]] <= 1'b0;
                W_ENH:   en_q[HALF +: DW]  <= bus_wdata;
                W_ENL:   en_q[0 +: DW]     <= bus_wdata;
                W_TYH:   typ_q[HALF +: DW] <= bus_wdata;
                W_TYL:   typ_q[0 +: DW]    <= bus_wdata;
                W_FRCH:  frc_q[HALF +: DW] <= bus_wdata;
                W_FRCL:  frc_q[0 +: DW]    <= bus_wdata;
                default: ;
            endcase
        end
    end

    // Read multiplexer selecting the addressed word.
    always_comb begin
        bus_rdata = '0;
        if (is_prio) begin
            bus_rdata = prio_q[pw_idx*DW +: DW];
        end
        case (bus_addr)
            W_CTL:   bus_rdata = ctl_q;
            W_LVL:   bus_rdata = DW'(lvl_q);
            W_ENH:   bus_rdata = en_q[HALF +: DW];
            W_ENL:   bus_rdata = en_q[0 +: DW];
            W_TYH:   bus_rdata = typ_q[HALF +: DW];
            W_TYL:   bus_rdata = typ_q[0 +: DW];
            W_NVEC:  bus_rdata = nvec_word;
            W_FVEC:  bus_rdata = fvec_word;
            W_RAWH:  bus_rdata = src_in[HALF +: DW];
            W_RAWL:  bus_rdata = src_in[0 +: DW];
            W_FRCH:  bus_rdata = frc_q[HALF +: DW];
            W_FRCL:  bus_rdata = frc_q[0 +: DW];
            W_NPH:   bus_rdata = npend[HALF +: DW];
            W_NPL:   bus_rdata = npend[0 +: DW];
            W_FPH:   bus_rdata = fpend[HALF +: DW];
            W_FPL:   bus_rdata = fpend[0 +: DW];
            default: ;
        endcase
    end
endmodule

// File: rtl/vic_route.sv
// Module: per-source qualification and routing.
// Combines line, force, enable, type and level threshold into normal and fast
// pending vectors. Purely combinational.
module vic_route
    import vic_pkg::*;
#(
    parameter int N  = NUM_SRC,
    parameter int PW = PRIO_W
) (
    input  logic [N-1:0]    src_in,
    input  logic [N-1:0]    frc_q,
    input  logic [N-1:0]    en_q,
    input  logic [N-1:0]    typ_q,
    input  logic [N*PW-1:0] prio_q,
    input  logic [4:0]      lvl_q,
    output logic [N-1:0]    npend,
    output logic [N-1:0]    fpend
);
    for (genvar s = 0; s < N; s++) begin : g_src
        logic live;
        logic lvl_pass;
        // A source is live when asserted and enabled.
        assign live     = (src_in[s] | frc_q[s]) & en_q[s];
        // Threshold bit 4 disables level masking altogether.
        assign lvl_pass = lvl_q[4] | (prio_q[s*PW +: PW] > PW'(lvl_q[3:0]));
        // Route on the type bit.
        assign npend[s] = live & ~typ_q[s] & lvl_pass;
        assign fpend[s] = live &  typ_q[s];
    end
endmodule

// File: rtl/vic_arbiter.sv
// Module: maximum-key tree arbiter.
// Each leaf key is {request, priority, source number}; the largest key wins,
// so ties go to the higher number. USE_PRIO=0 drops the priority field.
module vic_arbiter
    import vic_pkg::*;
#(
    parameter int N        = NUM_SRC,
    parameter int PW       = PRIO_W,
    parameter bit USE_PRIO = 1'b1
) (
    input  logic [N-1:0]         req,
    input  logic [N*PW-1:0]      prio,
    output logic                 win_valid,
    output logic [$clog2(N)-1:0] win_idx
);
    localparam int IW  = $clog2(N);
    localparam int EPW = USE_PRIO ? PW : 0;
    localparam int KW  = 1 + EPW + IW;

    logic [KW-1:0] node [2*N-1];

    // Leaves: build the comparison key of each source.
    for (genvar s = 0; s < N; s++) begin : g_leaf
        if (USE_PRIO) begin : g_p
            assign node[N-1+s] = {req[s], prio[s*PW +: PW], IW'(s)};
        end else begin : g_np
            logic unused_prio;
            assign unused_prio = ^prio[s*PW +: PW];
            assign node[N-1+s] = {req[s], IW'(s)};
        end
    end

    // Inner nodes: keep the larger key of the two children.
    for (genvar i = 0; i < N - 1; i++) begin : g_node
        assign node[i] = (node[2*i+1] > node[2*i+2]) ? node[2*i+1] : node[2*i+2];
    end

    assign win_valid = node[0][KW-1];
    assign win_idx   = node[0][IW-1:0];
endmodule

// File: rtl/vic_ctrl.sv
// Module: top of the vectored interrupt controller.
// Wires the register file, routing and two arbiters; forms the status words
// and request outputs. Assumes src_in is synchronous to clk.
module vic_ctrl
    import vic_pkg::*;
#(
    parameter int N  = NUM_SRC,
    parameter int PW = PRIO_W,
    parameter int DW = DATA_W,
    parameter int AW = ADDR_W
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          bus_wr,
    input  logic [AW-1:0] bus_addr,
    input  logic [DW-1:0] bus_wdata,
    output logic [DW-1:0] bus_rdata,
    input  logic [N-1:0]  src_in,
    output logic          norm_req,
    output logic          fast_req
);
    localparam int IW = $clog2(N);

    logic [N-1:0]    en_q, typ_q, frc_q, npend, fpend;
    logic [N*PW-1:0] prio_q;
    logic [4:0]      lvl_q;
    logic            n_valid, f_valid;
    logic [IW-1:0]   n_idx, f_idx;
    logic [DW-1:0]   nvec_word, fvec_word;

    vic_regs #(.N(N), .PW(PW), .DW(DW), .AW(AW)) u_regs (
        .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_addr(bus_addr),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .src_in(src_in),
        .npend(npend), .fpend(fpend), .nvec_word(nvec_word), .fvec_word(fvec_word),
        .en_q(en_q), .typ_q(typ_q), .frc_q(frc_q), .prio_q(prio_q), .lvl_q(lvl_q)
    );

    vic_route #(.N(N), .PW(PW)) u_route (
        .src_in(src_in), .frc_q(frc_q), .en_q(en_q), .typ_q(typ_q),
        .prio_q(prio_q), .lvl_q(lvl_q), .npend(npend), .fpend(fpend)
    );

    vic_arbiter #(.N(N), .PW(PW), .USE_PRIO(1'b1)) u_narb (
        .req(npend), .prio(prio_q), .win_valid(n_valid), .win_idx(n_idx)
    );

    vic_arbiter #(.N(N), .PW(PW), .USE_PRIO(1'b0)) u_farb (
        .req(fpend), .prio(prio_q), .win_valid(f_valid), .win_idx(f_idx)
    );

    // Status words: winner number in the upper half, sentinel when idle.
    assign nvec_word = {(n_valid ? 16'(n_idx) : VEC_NONE), 16'h0000};
    assign fvec_word = {(f_valid ? 16'(f_idx) : VEC_NONE), 16'h0000};

    // Request outputs follow the arbiters' valid flags.
    assign norm_req = n_valid;
    assign fast_req = f_valid;
endmodule

// File: rtl/vic_ctrl_chk.sv
// Module: property checker for vic_ctrl, attached by bind.
// Relates register state, pending vectors, status words and outputs.
module vic_ctrl_chk
    import vic_pkg::*;
#(
    parameter int N  = NUM_SRC,
    parameter int PW = PRIO_W,
    parameter int DW = DATA_W,
    parameter int AW = ADDR_W
) (
    input logic            clk,
    input logic            rst_n,
    input logic            bus_wr,
    input logic [AW-1:0]   bus_addr,
    input logic [DW-1:0]   bus_wdata,
    input logic [N-1:0]    en_q,
    input logic [N-1:0]    typ_q,
    input logic [N-1:0]    frc_q,
    input logic [N*PW-1:0] prio_q,
    input logic [4:0]      lvl_q,
    input logic [N-1:0]    npend,
    input logic [N-1:0]    fpend,
    input logic [DW-1:0]   nvec_word,
    input logic [DW-1:0]   fvec_word,
    input logic            norm_req,
    input logic            fast_req
);
    localparam int IW = $clog2(N);

    logic [15:0] nv, fv;
    assign nv = nvec_word[31:16];
    assign fv = fvec_word[31:16];

    AST_RESET_CLEAN: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rst_n) |-> (en_q == '0 && typ_q == '0 && frc_q == '0 && prio_q == '0 && lvl_q == 5'h1F)); // R1
    AST_ENSET_BIT: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_wr && bus_addr == W_ENSET && bus_wdata < DW'(N)) |=> en_q[$past(bus_wdata[IW-1:0])]); // R3
    AST_ENCLR_BIT: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_wr && bus_addr == W_ENCLR && bus_wdata < DW'(N)) |=> !en_q[$past(bus_wdata[IW-1:0])]); // R3
    AST_ROUTE_DISJOINT: assert property (@(posedge clk) disable iff (!rst_n)
        (npend & fpend) == '0); // R5
    AST_NVEC_PENDING: assert property (@(posedge clk) disable iff (!rst_n)
        (nv != VEC_NONE) |-> (nv < 16'(N) && npend[nv[IW-1:0]])); // R7
    AST_FVEC_PENDING: assert property (@(posedge clk) disable iff (!rst_n)
        (fv != VEC_NONE) |-> (fv < 16'(N) && fpend[fv[IW-1:0]])); // R10
    AST_LEVEL_PASS: assert property (@(posedge clk) disable iff (!rst_n)
        (nv != VEC_NONE && !lvl_q[4]) |-> (prio_q[nv[IW-1:0]*PW +: PW] > PW'(lvl_q[3:0]))); // R8
    AST_NREQ_STATUS: assert property (@(posedge clk) disable iff (!rst_n)
        norm_req == (nv != VEC_NONE && npend != '0)); // R11
    AST_FREQ_STATUS: assert property (@(posedge clk) disable iff (!rst_n)
        fast_req == (fv != VEC_NONE && fpend != '0)); // R11
    AST_STATUS_LOW_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        nvec_word[15:0] == 16'h0 && fvec_word[15:0] == 16'h0); // R7
endmodule

bind vic_ctrl vic_ctrl_chk #(.N(N), .PW(PW), .DW(DW), .AW(AW)) u_chk (
    .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .en_q(en_q), .typ_q(typ_q), .frc_q(frc_q),
    .prio_q(prio_q), .lvl_q(lvl_q), .npend(npend), .fpend(fpend),
    .nvec_word(nvec_word), .fvec_word(fvec_word),
    .norm_req(norm_req), .fast_req(fast_req)
);

// File: tb/vic_ctrl_tb.sv
`timescale 1ns/1ps
module vic_ctrl_tb;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bus_wr = 1'b0;
    logic [4:0]  bus_addr = '0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic [63:0] src_in = '0;
    logic        norm_req, fast_req;

    int n_checks = 0;
    int n_fail   = 0;
    bit done     = 1'b0;

    typedef struct {
        bit          outs;   // 1: compare {fast_req, norm_req}; 0: compare bus_rdata
        logic [31:0] exp;
        string       tag;
    } item_t;
    item_t sb[$];

    always #4 clk = ~clk;   // 125 MHz

    vic_ctrl u_dut (
        .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_addr(bus_addr),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .src_in(src_in),
        .norm_req(norm_req), .fast_req(fast_req)
    );

    // Monitor: pop the expected item and compare away from the clock edge.
    initial begin
        forever begin
            @(posedge clk);
            #2;
            if (sb.size() > 0) begin
                item_t it;
                logic [31:0] act;
                it  = sb.pop_front();
                act = it.outs ? {30'd0, fast_req, norm_req} : bus_rdata;
                n_checks++;
                if (act !== it.exp) begin
                    n_fail++;
                    $display("FAIL %s: actual %08h expected %08h", it.tag, act, it.exp);
                end
            end
        end
    end

    task automatic wr(input logic [4:0] a, input logic [31:0] d);
        @(negedge clk);
        bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
        @(negedge clk);
        bus_wr = 1'b0;
    endtask

    // Driver: set read address, push the expected item, let the monitor consume it.
    task automatic rd(input logic [4:0] a, input logic [31:0] e, input string tag);
        item_t it;
        @(negedge clk);
        bus_addr = a; bus_wr = 1'b0;
        it.outs = 1'b0; it.exp = e; it.tag = tag;
        sb.push_back(it);
        @(posedge clk); #3;
    endtask

    task automatic outs(input logic [1:0] e, input string tag);
        item_t it;
        @(negedge clk);
        it.outs = 1'b1; it.exp = {30'd0, e}; it.tag = tag;
        sb.push_back(it);
        @(posedge clk); #3;
    endtask

    // Watchdog: a hung run counts as a failure and still reports.
    initial begin
        #(8ns * 100000);
        if (!done) begin
            n_checks++; n_fail++;
            $display("FAIL watchdog: actual hung expected done");
            $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        // R1 reset state
        rd(5'd0,  32'h0,         "R1 control");
        rd(5'd1,  32'h1F,        "R1 threshold");
        rd(5'd4,  32'h0,         "R1 enable high");
        rd(5'd5,  32'h0,         "R1 enable low");
        rd(5'd7,  32'h0,         "R1 type low");
        rd(5'd15, 32'h0,         "R1 priority word");
        rd(5'd16, 32'hFFFF_0000, "R1 normal status");
        rd(5'd17, 32'hFFFF_0000, "R1 fast status");
        outs(2'b00,              "R1 outputs");
        // R2 readback and pair mapping
        wr(5'd0, 32'hA5A5_0001);
        rd(5'd0, 32'hA5A5_0001,  "R2 control readback");
        wr(5'd4, 32'h8000_0001);
        rd(5'd4, 32'h8000_0001,  "R2 enable high readback");
        rd(5'd5, 32'h0,          "R2 enable low untouched");
        wr(5'd4, 32'h0);
        // R3 by-number enable
        wr(5'd2, 32'd33);
        rd(5'd4, 32'h0000_0002,  "R3 set 33");
        wr(5'd2, 32'd5);
        rd(5'd5, 32'h0000_0020,  "R3 set 5");
        wr(5'd2, 32'd64);
        wr(5'd3, 32'd70);
        rd(5'd5, 32'h0000_0020,  "R3 out-of-range low");
        rd(5'd4, 32'h0000_0002,  "R3 out-of-range high");
        wr(5'd3, 32'd33);
        rd(5'd4, 32'h0,          "R3 clear 33");
        // R4/R5/R7/R11 single normal source
        @(negedge clk); src_in[5] = 1'b1;
        rd(5'd19, 32'h0000_0020, "R4 raw low");
        rd(5'd23, 32'h0000_0020, "R5 normal pending low");
        rd(5'd16, 32'h0005_0000, "R7 single winner");
        outs(2'b01,              "R11 normal only");
        // R4/R5 force on a disabled source
        wr(5'd20, 32'h0000_0100);
        rd(5'd18, 32'h0,         "R4 raw ignores force");
        rd(5'd22, 32'h0,         "R5 disabled not pending");
        wr(5'd2, 32'd40);
        rd(5'd22, 32'h0000_0100, "R5 forced pending");
        rd(5'd16, 32'h0028_0000, "R7 tie higher number");
        // R6/R10 route to fast
        wr(5'd6, 32'h0000_0100);
        rd(5'd22, 32'h0,         "R6 leaves normal");
        rd(5'd24, 32'h0000_0100, "R6 fast pending");
        rd(5'd17, 32'h0028_0000, "R10 fast status");
        rd(5'd16, 32'h0005_0000, "R7 remaining normal");
        outs(2'b11,              "R11 both");
        // R9 priority layout, R7 priority order
        wr(5'd15, 32'h0090_0000);
        rd(5'd15, 32'h0090_0000, "R9 word0 readback");
        wr(5'd2, 32'd10);
        @(negedge clk); src_in[10] = 1'b1;
        wr(5'd14, 32'h0000_0900);
        rd(5'd16, 32'h000A_0000, "R7 equal priority tie");
        wr(5'd14, 32'h0000_0300);
        rd(5'd16, 32'h0005_0000, "R9 R7 higher priority wins");
        // R8 threshold
        wr(5'd1, 32'd9);
        rd(5'd16, 32'hFFFF_0000, "R8 all held back");
        outs(2'b10,              "R8 fast unaffected");
        wr(5'd1, 32'd8);
        rd(5'd16, 32'h0005_0000, "R8 above threshold");
        wr(5'd1, 32'd3);
        rd(5'd23, 32'h0000_0020, "R8 equal priority held");
        wr(5'd1, 32'h1F);
        rd(5'd23, 32'h0000_0420, "R8 nothing held");
        // R10 fast idle
        wr(5'd6, 32'h0);
        wr(5'd20, 32'h0);
        rd(5'd17, 32'hFFFF_0000, "R10 fast idle");
        outs(2'b01,              "R11 normal only again");
        // R3 clear keeps others; R10 highest number
        wr(5'd3, 32'd5);
        rd(5'd5, 32'h0000_0400,  "R3 clear 5");
        rd(5'd16, 32'h000A_0000, "R7 after disable");
        @(negedge clk); src_in[7] = 1'b1;
        wr(5'd2, 32'd7);
        wr(5'd7, 32'h0000_0080);
        rd(5'd25, 32'h0000_0080, "R6 fast low");
        rd(5'd17, 32'h0007_0000, "R10 single fast");
        wr(5'd6, 32'h0000_0100);
        wr(5'd20, 32'h0000_0100);
        rd(5'd17, 32'h0028_0000, "R10 highest number");
        rd(5'd16, 32'h000A_0000, "R7 normal kept");
        repeat (2) @(negedge clk);
        done = 1'b1;
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end
endmodule